// File: doc/BRIEF.md
# Time-Slot Steered Mesh Crossbar

This block is the switching core of a five-port mesh router (north, south, east, west, local) whose input-to-output connections come from a programmable slot schedule instead of packet headers. A free-running slot counter walks through a rotation of `NUM_SLOTS` slots, which need not be a power of two, and selects one schedule row per clock. The row states, for each input, which output that input owns during the slot, or that it owns none. Single-flit data paths with a valid flag per port move through a registered crossbar. A flit therefore leaves this router one slot after it entered, which is the condition for schedules that advance by one slot per hop.

A central controller programs the schedule one entry per write. Writes land in a pending copy. The pending copy becomes the live schedule at the start of the next rotation, so a rotation never runs with a half-edited schedule. A write that would give one output to two inputs in the same slot is refused and answered with a one-cycle error pulse. Flits that arrive on an input with no reservation in the current slot are discarded and tallied in a saturating counter. A synchronous alignment input forces the slot counter back to slot 0 so that neighbouring routers share one slot phase.

Top module: `tdma_slot_switch`

## Requirements
- R1: The slot index shown on `slot_o` advances by one per clock from 0 to `NUM_SLOTS`-1 and then returns to 0, for power-of-two and other rotation lengths alike.
- R2: When `sync_i` is high at a clock edge, `slot_o` is 0 in the following cycle regardless of its previous value, and the rotation restarts from there.
- R3: A write names a slot (`cfg_slot`), an input (`cfg_in`: 0 north, 1 south, 2 east, 3 west, 4 local) and an output code (`cfg_out`: 0 to 4 select the output with the same numbering, 7 means no connection). A write with valid fields is accepted with `cfg_err` low in the following cycle, and code 7 removes the input's reservation in that slot.
- R4: An accepted write does not alter forwarding in the current rotation. It takes effect when the slot counter next enters slot 0, whether by wrap or by `sync_i`. A write made in the last slot of a rotation waits one more rotation.
- R5: A flit with its valid set on input i in slot s, where the live schedule maps i to output o, appears on output o with the same data in the next cycle, whose slot is (s+1) mod `NUM_SLOTS`.
- R6: An output's valid is low in the cycle after a slot in which no input is mapped to it, or in which the mapped input's valid was low.
- R7: A write whose output code 0 to 4 is already held by a different input in the same slot of the pending schedule is refused. The schedule is left unchanged, and `cfg_err` is high for exactly the following cycle.
- R8: A write with `cfg_slot` at or above `NUM_SLOTS`, `cfg_in` above 4, or `cfg_out` equal to 5 or 6 is refused with a one-cycle `cfg_err` pulse and leaves the schedule unchanged.
- R9: Each valid flit on an input that has no reservation in the current slot is discarded and raises `drop_count` by one in the next cycle. Several such flits in one cycle add together, and reserved flits add nothing.
- R10: `drop_count` stops at 2^`DROP_W`-1 and stays there.
- R11: After reset, the slot is 0, every schedule entry in both copies holds no connection, all output valids are low, `cfg_err` is low and `drop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Return the slot counter to slot 0 at the next edge |
| cfg_we | input | 1 | Schedule write strobe |
| cfg_slot | input | SLOT_W | Slot addressed by the write |
| cfg_in | input | 3 | Input port addressed by the write |
| cfg_out | input | 3 | Output code to store (0..4 port, 7 none) |
| cfg_err | output | 1 | One-cycle pulse for a refused write |
| in_valid | input | 5 | Flit valid per input port |
| in_data | input | 5*DATA_W | Flit data, input k at bits k*DATA_W upward |
| out_valid | output | 5 | Flit valid per output port |
| out_data | output | 5*DATA_W | Flit data, output k at bits k*DATA_W upward |
| slot_o | output | SLOT_W | Current slot index |
| drop_count | output | DROP_W | Saturating count of discarded flits |

## Verification
The main instance is built with a five-slot rotation, 16-bit flits and an 8-bit drop counter. This makes the non-power-of-two wrap, the pending-to-live hand-over and counter saturation reachable within a few dozen cycles. A second instance with eight slots runs beside it to cover the power-of-two counter variant. With five ports and five slots, every (slot, input) pair of the schedule is written. Traffic then runs over whole rotations with varied valid masks, and the expected output for each flit is derived arithmetically from the rotation mapping input i to output (i+s) mod 5.

// File: rtl/tdma_sw_pkg.sv
package tdma_sw_pkg;

   localparam int unsigned NPORTS = 5;
   localparam int unsigned PORT_W = 3;

   localparam logic [PORT_W-1:0] LINK_NONE  = 3'd7;
   localparam logic [PORT_W-1:0] PORT_LIMIT = 3'd5;

   typedef enum logic [PORT_W-1:0] {
      PORT_NORTH = 3'd0,
      PORT_SOUTH = 3'd1,
      PORT_EAST  = 3'd2,
      PORT_WEST  = 3'd3,
      PORT_LOCAL = 3'd4
   } port_e;

   function automatic logic code_is_port(input logic [PORT_W-1:0] code);
      return code < PORT_LIMIT;
   endfunction

endpackage

// File: rtl/tdma_slot_counter.sv
module tdma_slot_counter #(
   parameter int unsigned NUM_SLOTS = 5,
   parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_i,
   output logic [SLOT_W-1:0] slot_o,
   output logic              rollover_o
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
   localparam bit                IS_POW2   = (NUM_SLOTS & (NUM_SLOTS - 1)) == 0;

   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] slot_next;

   generate
      if (IS_POW2) begin : g_pow2_wrap
         // the register width matches the rotation, so overflow wraps it
         assign slot_next = slot_q + 1'b1;
      end else begin : g_cmp_wrap
         assign slot_next = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (sync_i) begin
         slot_q <= '0;
      end else begin
         slot_q <= slot_next;
      end
   end

   assign slot_o     = slot_q;
   assign rollover_o = sync_i | (slot_q == LAST_SLOT);

endmodule

// File: rtl/tdma_slot_table.sv
module tdma_slot_table
   import tdma_sw_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 5,
   parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SLOT_W-1:0]        wr_slot,
   input  logic [PORT_W-1:0]        wr_in,
   input  logic [PORT_W-1:0]        wr_out,
   input  logic                     commit_i,
   input  logic [SLOT_W-1:0]        rd_slot,
   output logic [NPORTS*PORT_W-1:0] rd_row,
   output logic                     wr_err_o
);

   localparam logic [SLOT_W:0] SLOT_LIMIT = (SLOT_W+1)'(NUM_SLOTS);

   logic [PORT_W-1:0] pend_q [NUM_SLOTS][NPORTS];
   logic [PORT_W-1:0] live_q [NUM_SLOTS][NPORTS];
   logic              err_q;

   logic              slot_ok, in_ok, code_ok, clash, accept;
   logic [SLOT_W-1:0] slot_idx;
   logic [PORT_W-1:0] in_idx;

   assign slot_ok  = {1'b0, wr_slot} < SLOT_LIMIT;
   assign in_ok    = code_is_port(wr_in);
   assign code_ok  = code_is_port(wr_out) || (wr_out == LINK_NONE);
   assign slot_idx = slot_ok ? wr_slot : '0;
   assign in_idx   = in_ok ? wr_in : '0;

   // output already owned by another input in the pending row
   always_comb begin
      clash = 1'b0;
      for (int j = 0; j < NPORTS; j++) begin
         if ((PORT_W'(j) != wr_in) && code_is_port(wr_out) &&
             (pend_q[slot_idx][j] == wr_out)) begin
            clash = 1'b1;
         end
      end
   end

   assign accept = wr_en & slot_ok & in_ok & code_ok & ~clash;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
         for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int p = 0; p < NPORTS; p++) begin
               pend_q[s][p] <= LINK_NONE;
               live_q[s][p] <= LINK_NONE;
            end
         end
      end else begin
         err_q <= wr_en & ~accept;
         if (commit_i) begin
            live_q <= pend_q;
         end
         if (accept) begin
            pend_q[slot_idx][in_idx] <= wr_out;
         end
      end
   end

   generate
      for (genvar p = 0; p < NPORTS; p++) begin : g_row
         assign rd_row[p*PORT_W +: PORT_W] = live_q[rd_slot][p];
      end
   endgenerate

   assign wr_err_o = err_q;

endmodule

// File: rtl/tdma_xbar.sv
module tdma_xbar
   import tdma_sw_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPORTS*PORT_W-1:0] row,
   input  logic [NPORTS-1:0]        in_valid,
   input  logic [NPORTS*DATA_W-1:0] in_data,
   output logic [NPORTS-1:0]        out_valid,
   output logic [NPORTS*DATA_W-1:0] out_data,
   output logic [NPORTS-1:0]        drop_vec
);

   generate
      for (genvar i = 0; i < NPORTS; i++) begin : g_drop
         assign drop_vec[i] = in_valid[i] & ~code_is_port(row[i*PORT_W +: PORT_W]);
      end

      for (genvar o = 0; o < NPORTS; o++) begin : g_out
         logic              sel_valid;
         logic [DATA_W-1:0] sel_data;

         // the schedule never maps two inputs to one output, so AND-OR suffices
         always_comb begin
            sel_valid = 1'b0;
            sel_data  = '0;
            for (int i = 0; i < NPORTS; i++) begin
               if (row[i*PORT_W +: PORT_W] == PORT_W'(o)) begin
                  sel_valid = sel_valid | in_valid[i];
                  sel_data  = sel_data | in_data[i*DATA_W +: DATA_W];
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid[o]                  <= 1'b0;
               out_data[o*DATA_W +: DATA_W]  <= '0;
            end else begin
               out_valid[o]                  <= sel_valid;
               out_data[o*DATA_W +: DATA_W]  <= sel_data;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tdma_drop_counter.sv
module tdma_drop_counter #(
   parameter int unsigned DROP_W = 8,
   parameter int unsigned LANES  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES-1:0]  drop_vec,
   output logic [DROP_W-1:0] count_o
);

   localparam logic [DROP_W:0] CAP = {1'b0, {DROP_W{1'b1}}};

   logic [DROP_W-1:0] count_q;
   logic [DROP_W:0]   inc, sum;

   assign inc = (DROP_W+1)'($countones(drop_vec));
   assign sum = {1'b0, count_q} + inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (sum > CAP) begin
         count_q <= CAP[DROP_W-1:0];
      end else begin
         count_q <= sum[DROP_W-1:0];
      end
   end

   assign count_o = count_q;

endmodule

// File: rtl/tdma_slot_switch.sv
module tdma_slot_switch
   import tdma_sw_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 5,
   parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS),
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DROP_W    = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sync_i,
   input  logic                     cfg_we,
   input  logic [SLOT_W-1:0]        cfg_slot,
   input  logic [PORT_W-1:0]        cfg_in,
   input  logic [PORT_W-1:0]        cfg_out,
   output logic                     cfg_err,
   input  logic [NPORTS-1:0]        in_valid,
   input  logic [NPORTS*DATA_W-1:0] in_data,
   output logic [NPORTS-1:0]        out_valid,
   output logic [NPORTS*DATA_W-1:0] out_data,
   output logic [SLOT_W-1:0]        slot_o,
   output logic [DROP_W-1:0]        drop_count
);

   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("NUM_SLOTS must be at least 2");
      end
      if (SLOT_W != $clog2(NUM_SLOTS)) begin : g_bad_slot_w
         $error("SLOT_W must equal clog2(NUM_SLOTS)");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (DROP_W < 3) begin : g_bad_drop
         $error("DROP_W must be at least 3 to absorb five drops per cycle");
      end
   endgenerate

   logic                     rollover;
   logic [NPORTS*PORT_W-1:0] live_row;
   logic [NPORTS-1:0]        drop_vec;

   tdma_slot_counter #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W)
   ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_i     (sync_i),
      .slot_o     (slot_o),
      .rollover_o (rollover)
   );

   tdma_slot_table #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_slot  (cfg_slot),
      .wr_in    (cfg_in),
      .wr_out   (cfg_out),
      .commit_i (rollover),
      .rd_slot  (slot_o),
      .rd_row   (live_row),
      .wr_err_o (cfg_err)
   );

   tdma_xbar #(
      .DATA_W (DATA_W)
   ) u_xbar (
      .clk       (clk),
      .rst_n     (rst_n),
      .row       (live_row),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data),
      .drop_vec  (drop_vec)
   );

   tdma_drop_counter #(
      .DROP_W (DROP_W),
      .LANES  (NPORTS)
   ) u_drops (
      .clk      (clk),
      .rst_n    (rst_n),
      .drop_vec (drop_vec),
      .count_o  (drop_count)
   );

endmodule

// File: rtl/tdma_slot_switch_chk.sv
module tdma_slot_switch_chk #(
   parameter int unsigned NUM_SLOTS = 5,
   parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS),
   parameter int unsigned DROP_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sync_i,
   input logic              cfg_we,
   input logic              cfg_err,
   input logic [4:0]        in_valid,
   input logic [4:0]        out_valid,
   input logic [SLOT_W-1:0] slot_o,
   input logic [DROP_W-1:0] drop_count
);

   localparam logic [SLOT_W:0]   SLOT_LIMIT = (SLOT_W+1)'(NUM_SLOTS);
   localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(NUM_SLOTS - 1);
   localparam logic [DROP_W-1:0] DROP_MAX   = {DROP_W{1'b1}};

   // R1
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, slot_o} < SLOT_LIMIT));

   // R1
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_i && slot_o != LAST_SLOT) |=> (slot_o == SLOT_W'($past(slot_o) + 1'b1)));

   // R1
   slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_o == LAST_SLOT) |=> (slot_o == '0));

   // R2
   sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> (slot_o == '0));

   // R6
   out_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 ($countones(out_valid) <= $past($countones(in_valid))));

   // R7
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(cfg_we));

   // R9
   drop_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 (drop_count >= $past(drop_count)));

   // R10
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_count == DROP_MAX) |=> (drop_count == DROP_MAX));

endmodule

bind tdma_slot_switch tdma_slot_switch_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .SLOT_W    (SLOT_W),
   .DROP_W    (DROP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sync_i     (sync_i),
   .cfg_we     (cfg_we),
   .cfg_err    (cfg_err),
   .in_valid   (in_valid),
   .out_valid  (out_valid),
   .slot_o     (slot_o),
   .drop_count (drop_count)
);

// File: tb/tb_tdma_slot_switch.sv
module tb_tdma_slot_switch;

   localparam int NS  = 5;
   localparam int SW  = 3;
   localparam int DW  = 16;
   localparam int DRW = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sync_i = 1'b0;
   logic           cfg_we = 1'b0;
   logic [SW-1:0]  cfg_slot = '0;
   logic [2:0]     cfg_in = '0;
   logic [2:0]     cfg_out = '0;
   logic           cfg_err;
   logic [4:0]     in_valid = '0;
   logic [5*DW-1:0] in_data = '0;
   logic [4:0]     out_valid;
   logic [5*DW-1:0] out_data;
   logic [SW-1:0]  slot_o;
   logic [DRW-1:0] drop_count;

   logic           p2_err;
   logic [4:0]     p2_valid;
   logic [5*DW-1:0] p2_data;
   logic [2:0]     p2_slot;
   logic [DRW-1:0] p2_drops;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   tdma_slot_switch #(.NUM_SLOTS(NS), .SLOT_W(SW), .DATA_W(DW), .DROP_W(DRW)) dut (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
      .cfg_in(cfg_in), .cfg_out(cfg_out), .cfg_err(cfg_err), .in_valid(in_valid),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .slot_o(slot_o),
      .drop_count(drop_count));

   tdma_slot_switch #(.NUM_SLOTS(8), .SLOT_W(3), .DATA_W(DW), .DROP_W(DRW)) dut_p2 (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .cfg_we(1'b0), .cfg_slot(3'd0),
      .cfg_in(3'd0), .cfg_out(3'd0), .cfg_err(p2_err), .in_valid(5'd0),
      .in_data('0), .out_valid(p2_valid), .out_data(p2_data), .slot_o(p2_slot),
      .drop_count(p2_drops));

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
      check(act === exp, req, act, exp);
   endtask

   function automatic logic [DW-1:0] out_word(input int o);
      return out_data[o*DW +: DW];
   endfunction

   task automatic set_in(input int i, input logic [DW-1:0] d);
      in_data[i*DW +: DW] = d;
   endtask

   // returns at the negedge after the write; cfg_err then reflects it
   task automatic cfg_write(input int s, input int i, input int o, output logic err);
      cfg_we = 1'b1; cfg_slot = SW'(s); cfg_in = 3'(i); cfg_out = 3'(o);
      @(negedge clk);
      cfg_we = 1'b0;
      err = cfg_err;
   endtask

   task automatic wait_slot(input int s);
      while (slot_o != SW'(s)) @(negedge clk);
   endtask

   task automatic wait_rotation();
      wait_slot(NS - 1);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic err;
      int   s;
      logic [4:0] mask, expv;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      cmp("R11 slot", slot_o, 0);
      cmp("R11 out_valid", out_valid, 0);
      cmp("R11 drops", drop_count, 0);
      cmp("R11 cfg_err", cfg_err, 0);

      // R1 rotation for 5 and 8 slots
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         cmp("R1 slot5", slot_o, k % 5);
         cmp("R1 slot8", p2_slot, k % 8);
      end

      // R2 alignment
      wait_slot(3);
      sync_i = 1'b1;
      @(negedge clk);
      sync_i = 1'b0;
      cmp("R2 slot5 after sync", slot_o, 0);
      cmp("R2 slot8 after sync", p2_slot, 0);
      @(negedge clk);
      cmp("R2 slot after restart", slot_o, 1);

      // R9 / R6 drops on an empty schedule
      in_valid = 5'b00101;
      @(negedge clk);
      cmp("R6 empty out", out_valid, 0);
      cmp("R9 two drops", drop_count, 2);
      in_valid = 5'b11111;
      @(negedge clk);
      in_valid = '0;
      cmp("R9 five drops", drop_count, 7);

      // R4 pending until next rotation
      wait_slot(1);
      cfg_write(3, 0, 2, err);
      cmp("R3 accept", err, 0);
      @(negedge clk);
      in_valid = 5'b00001; set_in(0, 16'hA5A5);
      @(negedge clk);
      in_valid = '0;
      cmp("R4 not yet live", out_valid, 0);
      cmp("R4 slot", slot_o, 4);
      cmp("R9 pending drop", drop_count, 8);
      wait_slot(3);
      in_valid = 5'b00001; set_in(0, 16'hA5A5);
      @(negedge clk);
      in_valid = '0;
      cmp("R5 live valid", out_valid, 5'b00100);
      cmp("R5 live data", out_word(2), 16'hA5A5);
      cmp("R9 no drop when mapped", drop_count, 8);

      // R3 full schedule: input i -> output (i+s) mod 5
      for (int ws = 0; ws < NS; ws++) begin
         for (int wi = 0; wi < 5; wi++) begin
            cfg_write(ws, wi, (wi + ws) % 5, err);
            cmp("R3 sweep accept", err, 0);
         end
      end
      wait_rotation();

      // R5 / R6 traffic over three rotations
      for (int c = 0; c < 15; c++) begin
         s = int'(slot_o);
         mask = (c == 0) ? 5'b11111 : 5'((c * 13 + 7) % 32);
         in_valid = mask;
         for (int i = 0; i < 5; i++) set_in(i, DW'((c << 8) | (i << 4) | s));
         @(negedge clk);
         in_valid = '0;
         for (int o = 0; o < 5; o++) expv[o] = mask[(o + 5 - s) % 5];
         cmp("R6 valid pattern", out_valid, expv);
         cmp("R5 next slot", slot_o, (s + 1) % NS);
         for (int o = 0; o < 5; o++) begin
            if (expv[o])
               cmp("R5 data", out_word(o), DW'((c << 8) | (((o + 5 - s) % 5) << 4) | s));
         end
      end
      cmp("R9 unchanged", drop_count, 8);

      // R7 conflict
      cfg_write(2, 1, 2, err);
      cmp("R7 conflict err", err, 1);
      @(negedge clk);
      cmp("R7 pulse ends", cfg_err, 0);

      // R8 malformed writes
      cfg_write(5, 0, 0, err);
      cmp("R8 bad slot", err, 1);
      cfg_write(0, 5, 0, err);
      cmp("R8 bad input", err, 1);
      cfg_write(0, 0, 6, err);
      cmp("R8 code 6", err, 1);
      cfg_write(0, 0, 5, err);
      cmp("R8 code 5", err, 1);

      // R3 clear a reservation
      cfg_write(1, 4, 7, err);
      cmp("R3 clear accept", err, 0);
      wait_rotation();

      wait_slot(2);
      in_valid = 5'b00011; set_in(0, 16'h1111); set_in(1, 16'h2222);
      @(negedge clk);
      in_valid = '0;
      cmp("R7 table kept valid", out_valid, 5'b01100);
      cmp("R7 table kept out2", out_word(2), 16'h1111);
      cmp("R7 table kept out3", out_word(3), 16'h2222);

      wait_slot(1);
      in_valid = 5'b10000; set_in(4, 16'h4444);
      @(negedge clk);
      in_valid = '0;
      cmp("R6 cleared output low", out_valid, 0);
      cmp("R9 cleared drop", drop_count, 9);

      wait_slot(0);
      in_valid = 5'b00001; set_in(0, 16'h0F0F);
      @(negedge clk);
      in_valid = '0;
      cmp("R8 slot0 unchanged", out_valid, 5'b00001);
      cmp("R8 slot0 data", out_word(0), 16'h0F0F);

      // R10 saturation after a fresh reset
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      cmp("R11 drops cleared", drop_count, 0);
      in_valid = 5'b11111;
      for (int k = 1; k <= 60; k++) begin
         @(negedge clk);
         if (k == 10) cmp("R9 running sum", drop_count, 50);
         if (k == 20) cmp("R11 schedule cleared", out_valid, 0);
      end
      cmp("R10 saturated", drop_count, 255);
      @(negedge clk);
      in_valid = '0;
      cmp("R10 held", drop_count, 255);

      if (!finished) begin
         finished = 1'b1;
         summary();
         $finish;
      end
   end

endmodule